// File: doc/BRIEF.md
# Converter Bus Interface Sequencer

This block is the digital control side of a small analog I/O peripheral that shares one 8-bit microprocessor bus between a DAC and an ADC. A chip-select-qualified write strobe loads the DAC data register. An asynchronous active-low reset clears that register and returns the ADC side to its ready state. Conversions start in one of two ways. In strobe-start mode, a falling edge on a dedicated start pin begins a conversion, and chip select plays no part. In read-start mode, a read access with chip select low begins one.

The analog conversion is modelled as a fixed number of clock cycles. The digital code comes from a sample input, which is latched when the conversion starts. The result is presented on the data bus together with a drive enable meant for an external pad buffer. Busy and interrupt status are both active low. The interrupt flag stays raised until the host releases chip select or read.

All strobes are sampled on the converter clock. Their edges are found by comparing each strobe with its value one cycle earlier.

Top module: `conv_bus_seq`

## Requirements
- R1: A low-to-high transition of `wr_n`, seen while `cs_n` is low, loads `bus_in` into `dac_q`. The new value is visible after the clock edge at which `wr_n` is first sampled high.
- R2: `dac_q` keeps its value when `wr_n` rises while `cs_n` is high. It also keeps its value while `cs_n` is low and `wr_n` does not rise.
- R3: While `rst_n` is low, the block is held in its reset state: `dac_q` is 0, `busy_n` and `irq_n` are 1, `bus_oe` is 0 and the stored result is 0. This takes effect without a clock edge, aborts any conversion in progress, and no conversion starts afterwards without a new start request.
- R4: With `rd_mode` = 0, a falling edge on `start_n` starts a conversion whatever the level of `cs_n`. `busy_n` is low after the clock edge that sees the fall. A read access does not start a conversion in this mode.
- R5: With `rd_mode` = 1, a falling edge on `rd_n` while `cs_n` is low starts a conversion, with the same timing as R4. A fall on `start_n` does not start a conversion in this mode.
- R6: `busy_n` stays low for exactly `CONV_CYCLES` clock cycles. It returns high at the same clock edge at which `irq_n` goes low.
- R7: A rising edge on `cs_n` or on `rd_n` sets `irq_n` high at the next clock edge. If a conversion completes at that same edge, completion wins and `irq_n` goes low.
- R8: `sample_code` is latched at the clock edge that starts a conversion, and later changes to it do not affect that conversion. A start request that arrives while `busy_n` is low is ignored and does not lengthen the conversion.
- R9: With `fmt_signed` = 0 the result equals the latched sample (straight binary). With `fmt_signed` = 1 the result is the sample with bit 7 inverted (two's complement for the bipolar ranges). The format is taken at the starting edge.
- R10: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low, and it follows them without a clock edge. While it is 1, `bus_out` carries the result. While it is 0, `bus_out` is 0.
- R11: The result holds the last completed conversion until the next conversion completes. While a conversion is in progress, a read returns the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | DAC write strobe, loads on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| start_n | input | 1 | Start-conversion strobe, acts on its falling edge |
| rd_mode | input | 1 | 0: start by `start_n`; 1: start by a read |
| fmt_signed | input | 1 | 0: straight binary; 1: two's complement |
| bus_in | input | 8 | Data from the host for the DAC register |
| sample_code | input | 8 | Digitised analog sample from the converter model |
| dac_q | output | 8 | DAC data register |
| bus_out | output | 8 | Conversion result toward the bus |
| bus_oe | output | 1 | Drive enable for the bus pads |
| busy_n | output | 1 | Conversion in progress, active low |
| irq_n | output | 1 | Conversion complete, active low |

## Verification
A DAC write becomes visible one clock edge after `wr_n` rises. Busy falls one edge after the start strobe and rises `CONV_CYCLES` edges later, at the same edge that drops the interrupt. The interrupt clears one edge after the releasing strobe rises. The bus enable is combinational and needs no edge at all.

The bench drives inputs just after a falling clock edge and samples at the following falling edges, counting elapsed edges from the starting one. It therefore checks busy low at count `CONV_CYCLES` and high at count `CONV_CYCLES`+1. The enable and the bus value are checked a short delay after the strobes change, before any edge. The reset response is checked the same way, before a clock edge follows.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic st_n;
    } strobe_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_CONV = 1'b1
    } conv_state_e;

endpackage

// File: rtl/strobe_edges.sv
module strobe_edges
    import conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic start_n,
    output logic dac_load,
    output logic st_fall,
    output logic rd_start,
    output logic flag_clr
);

    strobe_t prev_d, prev_q;

    always_comb begin
        prev_d.cs_n = cs_n;
        prev_d.wr_n = wr_n;
        prev_d.rd_n = rd_n;
        prev_d.st_n = start_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, st_n: 1'b1};
        else        prev_q <= prev_d;
    end

    // Edges are found by comparing each strobe with its value one cycle earlier.
    always_comb begin
        dac_load = !prev_q.wr_n && wr_n && !cs_n;
        st_fall  = prev_q.st_n && !start_n;
        rd_start = prev_q.rd_n && !rd_n && !cs_n;
        flag_clr = (!prev_q.cs_n && cs_n) || (!prev_q.rd_n && rd_n);
    end

    // R4: a fall of the start pin is a single-cycle event
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_fall |=> !st_fall);

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dac_q
);

    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) val_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign dac_q = val_q;

    p_dac_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dac_q == $past(din)));

    p_dac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_q));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import conv_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CONV_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_mode,
    input  logic              fmt_signed,
    input  logic              st_fall,
    input  logic              rd_start,
    input  logic              flag_clr,
    input  logic [DATA_W-1:0] sample_code,
    output logic              busy_n,
    output logic              irq_n,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int RUN_W = $clog2(CONV_CYCLES + 2) + 1;
    localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        conv_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] cap;
        logic [DATA_W-1:0] res;
        logic              busy_n;
        logic              irq_n;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{state: S_IDLE, cnt: '0, cap: '0, res: '0,
                                   busy_n: 1'b1, irq_n: 1'b1};

    ctrl_t ctl_d, ctl_q;
    logic  start_req;

    always_comb begin
        ctl_d     = ctl_q;
        start_req = rd_mode ? rd_start : st_fall;
        if (flag_clr) ctl_d.irq_n = 1'b1;
        case (ctl_q.state)
            S_IDLE: begin
                if (start_req) begin
                    ctl_d.state  = S_CONV;
                    ctl_d.cnt    = CNT_LAST;
                    ctl_d.cap    = sample_code ^ (fmt_signed ? SIGN_FLIP : '0);
                    ctl_d.busy_n = 1'b0;
                end
            end
            S_CONV: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state  = S_IDLE;
                    ctl_d.busy_n = 1'b1;
                    ctl_d.irq_n  = 1'b0;
                    ctl_d.res    = ctl_q.cap;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RST;
        else        ctl_q <= ctl_d;
    end

    assign busy_n = ctl_q.busy_n;
    assign irq_n  = ctl_q.irq_n;
    assign result = ctl_q.res;

    // Checker-only run length of the busy pulse
    logic [RUN_W-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_run <= '0;
        else if (busy_n)                low_run <= '0;
        else if (low_run != {RUN_W{1'b1}}) low_run <= low_run + 1'b1;
    end

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_run == RUN_W'(CONV_CYCLES)));

    p_irq_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> !irq_n);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && busy_n) |=> irq_n);

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |=> $stable(ctl_q.cap));

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |=> $stable(result));

endmodule

// File: rtl/conv_bus_seq.sv
module conv_bus_seq #(
    parameter int DATA_W      = 8,
    parameter int CONV_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              start_n,
    input  logic              rd_mode,
    input  logic              fmt_signed,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] sample_code,
    output logic [DATA_W-1:0] dac_q,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              busy_n,
    output logic              irq_n
);

    logic              dac_load;
    logic              st_fall;
    logic              rd_start;
    logic              flag_clr;
    logic [DATA_W-1:0] result;

    strobe_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .start_n  (start_n),
        .dac_load (dac_load),
        .st_fall  (st_fall),
        .rd_start (rd_start),
        .flag_clr (flag_clr)
    );

    dac_hold_reg #(.DATA_W(DATA_W)) u_dac (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dac_load),
        .din   (bus_in),
        .dac_q (dac_q)
    );

    adc_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_adc (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_mode     (rd_mode),
        .fmt_signed  (fmt_signed),
        .st_fall     (st_fall),
        .rd_start    (rd_start),
        .flag_clr    (flag_clr),
        .sample_code (sample_code),
        .busy_n      (busy_n),
        .irq_n       (irq_n),
        .result      (result)
    );

    // The pads are driven only during a selected read.
    always_comb begin
        bus_oe  = !cs_n && !rd_n;
        bus_out = bus_oe ? result : '0;
    end

    // R10: the bus carries the stored result whenever it is driven
    p_bus_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_out == result));

endmodule

// File: tb/conv_bus_seq_tb_top.sv
module conv_bus_seq_tb_top;

    localparam int NC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, start_n = 1'b1;
    logic       rd_mode = 1'b0, fmt_signed = 1'b0;
    logic [7:0] bus_in = '0, sample_code = '0;
    logic [7:0] dac_q, bus_out;
    logic       bus_oe, busy_n, irq_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    conv_bus_seq #(.DATA_W(8), .CONV_CYCLES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .start_n(start_n), .rd_mode(rd_mode), .fmt_signed(fmt_signed),
        .bus_in(bus_in), .sample_code(sample_code), .dac_q(dac_q),
        .bus_out(bus_out), .bus_oe(bus_oe), .busy_n(busy_n), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dac_write(input logic sel_n, input logic [7:0] v);
        cs_n = sel_n; bus_in = v; wr_n = 1'b0;
        step(1);
        wr_n = 1'b1;
        step(1);
        cs_n = 1'b1;
        step(1);
    endtask

    logic [7:0] prev_res = 8'h00;

    task automatic convert(input logic m, input logic f, input logic [7:0] c);
        logic [7:0] exp_v;
        exp_v = f ? (c ^ 8'h80) : c;
        rd_mode = m; fmt_signed = f; sample_code = c;
        if (m) begin
            // R5: start pin is not a trigger in read-start mode
            start_n = 1'b0; step(1); start_n = 1'b1;
            chk(busy_n == 1'b1, "R5 start pin ignored", busy_n, 1);
            cs_n = 1'b0; rd_n = 1'b0;
            step(1);
            chk(busy_n == 1'b0, "R5 read start", busy_n, 0);
            rd_n = 1'b1; cs_n = 1'b1;
        end else begin
            cs_n = 1'b1; start_n = 1'b0;
            step(1);
            chk(busy_n == 1'b0, "R4 start pin", busy_n, 0);
            start_n = 1'b1;
        end
        sample_code = ~c;
        for (int k = 1; k < NC; k++) begin
            if (k == 2) begin
                if (m) begin cs_n = 1'b0; rd_n = 1'b0; end
                else start_n = 1'b0;
            end
            if (k == 3) begin
                rd_n = 1'b1; cs_n = 1'b1; start_n = 1'b1;
            end
            if (!m && k == 5) begin
                cs_n = 1'b0; rd_n = 1'b0;
                #1;
                chk(bus_out == prev_res, "R11 old result during conversion", bus_out, prev_res);
            end
            if (!m && k == 6) begin
                rd_n = 1'b1; cs_n = 1'b1;
            end
            step(1);
        end
        chk(busy_n == 1'b0, "R6 busy still low at last cycle", busy_n, 0);
        step(1);
        chk(busy_n == 1'b1, "R6 busy released", busy_n, 1);
        chk(irq_n == 1'b0, "R6 irq with busy release", irq_n, 0);
        sample_code = c;
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk(bus_oe == 1'b1, "R10 enable on read", bus_oe, 1);
        chk(bus_out == exp_v, "R9 formatted result", bus_out, exp_v);
        step(1);
        if (!m) begin
            chk(busy_n == 1'b1, "R4 read does not start", busy_n, 1);
            rd_n = 1'b1;
            #1;
            chk(bus_oe == 1'b0, "R10 enable drops", bus_oe, 0);
            step(1);
            chk(irq_n == 1'b1, "R7 clear by read rise", irq_n, 1);
            cs_n = 1'b1;
            step(1);
        end else begin
            rd_n = 1'b1; cs_n = 1'b1;
            step(NC + 1);
            chk(irq_n == 1'b0, "R6 second conversion done", irq_n, 0);
            cs_n = 1'b0; step(1);
            cs_n = 1'b1; step(1);
            chk(irq_n == 1'b1, "R7 clear by select rise", irq_n, 1);
        end
        prev_res = exp_v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(2);
        chk(dac_q == 8'h00, "R3 reset dac", dac_q, 0);
        chk(busy_n == 1'b1, "R3 reset busy", busy_n, 1);
        chk(irq_n == 1'b1, "R3 reset irq", irq_n, 1);
        chk(bus_oe == 1'b0, "R10 reset enable", bus_oe, 0);
        rst_n = 1'b1;
        step(2);

        for (int v = 0; v < 256; v++) begin
            dac_write(1'b0, 8'(v));
            chk(dac_q == 8'(v), "R1 dac load", dac_q, v);
            dac_write(1'b1, ~8'(v));
            chk(dac_q == 8'(v), "R2 dac hold unselected", dac_q, v);
            if (v % 32 == 0) begin
                cs_n = 1'b0; bus_in = 8'h3C; step(2); cs_n = 1'b1; step(1);
                chk(dac_q == 8'(v), "R2 dac hold no edge", dac_q, v);
            end
        end

        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 2; f++)
                for (int c = 0; c < 256; c++)
                    convert(m[0], f[0], 8'(c));

        dac_write(1'b0, 8'hA5);
        rd_mode = 1'b0; start_n = 1'b0; step(1); start_n = 1'b1;
        step(3);
        rst_n = 1'b0;
        #1;
        chk(dac_q == 8'h00, "R3 async dac clear", dac_q, 0);
        chk(busy_n == 1'b1, "R3 async busy release", busy_n, 1);
        chk(irq_n == 1'b1, "R3 async irq high", irq_n, 1);
        step(2);
        rst_n = 1'b1;
        step(NC + 3);
        chk(busy_n == 1'b1, "R3 aborted conversion stays idle", busy_n, 1);
        chk(irq_n == 1'b1, "R3 no completion after abort", irq_n, 1);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(bus_out == 8'h00, "R3 result cleared", bus_out, 0);
        rd_n = 1'b1; cs_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule